// File: doc/BRIEF.md
# Companded PCM Serial Port

This block is the serial front end of a voice processor. It carries two receive lanes and two transmit lanes of 8-bit companded telephone samples. An external bit clock and a frame strobe, nominally 8 kHz, set the timing. The block samples the bit clock and the strobe in its own system clock domain and acts on the edges it detects. A falling bit-clock edge captures received bits. A rising bit-clock edge launches transmit bits, so each bit is stable when the far end samples it on the next falling edge.

Each received byte is expanded to a left-aligned 16-bit linear sample. A one-cycle strobe marks it once both lanes are complete. Each 16-bit linear sample to be sent is compressed when its slot starts and then shifted out MSB first. A select input chooses mu-law or A-law. Each transmit lane has a data output and an output enable for an external tri-state pad. The enable is low outside the 8-bit slot, during reset and during power-down.

Top module: `pcm_serial_port`

## Requirements
- R1: While `rst_n` is low (asynchronous), and in the first clock after it returns high, both output enables are low, `rx_valid` is low and both linear receive outputs are zero.
- R2: A falling bit-clock edge with `fsync` high captures bit 7 of each receive lane. The next seven falling edges capture bits 6 down to 0.
- R3: `rx_valid` is high for exactly one clock, in the clock after the one in which the eighth falling edge is detected. Both linear outputs update in that same clock and hold until the next completed byte.
- R4: A rising bit-clock edge with `fsync` high raises both output enables and drives bit 7 of each compressed code. Each following rising edge advances one bit. The rising edge after bit 0 lowers the enables. Data changes only after a rising edge.
- R5: Outside the 8-bit transmit slot, both output enables stay low.
- R6: When `law_mu` is 1, mu-law is used on `lin[15:2]` (14-bit two's complement). The magnitude is clipped to 8158 and biased by 33. The segment is the leading-one position minus 5 and the mantissa is the next four bits. The code {0,seg,man} is XORed with 0xFF for a non-negative sample and 0x7F for a negative one. Encoding examples: 0x0000→0xFF, 0x7FFC→0x80, 0xFFFC→0x7E. Decoding examples: 0xFF→0x0000, 0x80→0x7D7C, 0x7E→0xFFF8.
- R7: When `law_mu` is 0, A-law is used on `lin[15:3]` (13-bit two's complement), with the one's complement as the magnitude of a negative sample. Segment k covers magnitudes below 32<<k. The code {0,seg,man} is XORed with 0xD5 for a non-negative sample and 0x55 for a negative one. Encoding examples: 0x0000→0xD5, 0xFFF8→0x55, 0x7FF8→0xAA. Decoding examples: 0xD5→0x0008, 0x55→0xFFF8, 0xAA→0x7E00.
- R8: The frame strobe takes priority over a byte in progress. A falling edge with `fsync` high restarts reception and discards the partial byte, even on what would have been its last bit, so no `rx_valid` follows. A rising edge with `fsync` high reloads the transmit slot, even on the edge that would have ended it.
- R9: While `pwr_en` is low, both output enables are low at once and all framing state is cleared. After `pwr_en` returns high, the enables stay low until a new frame starts.
- R10: The law select is sampled at the rising edge that starts a transmit slot, for encoding, and at the falling edge that completes a received byte, for decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_en | input | 1 | 1 = operate, 0 = power-down |
| law_mu | input | 1 | 1 = mu-law, 0 = A-law |
| bclk | input | 1 | Serial bit clock, synchronous to clk |
| fsync | input | 1 | Frame strobe |
| rx_a | input | 1 | Serial receive lane A |
| rx_b | input | 1 | Serial receive lane B |
| rx_lin_a | output | 16 | Expanded linear sample, lane A |
| rx_lin_b | output | 16 | Expanded linear sample, lane B |
| rx_valid | output | 1 | One-cycle strobe: both linear samples updated |
| tx_lin_a | input | 16 | Linear sample to send, lane A |
| tx_lin_b | input | 16 | Linear sample to send, lane B |
| tx_a_d | output | 1 | Serial transmit data, lane A |
| tx_a_oe | output | 1 | Output enable for lane A pad |
| tx_b_d | output | 1 | Serial transmit data, lane B |
| tx_b_oe | output | 1 | Output enable for lane B pad |

## Verification
Two events can share one bit-clock edge. In back-to-back frames of exactly eight bits, the rising edge that would close a transmit slot is also the edge that opens the next one, so the enable must stay high and bit 7 of the new code must appear. When a strobe arrives early, including on the falling edge that would capture bit 0, the restart must win over byte completion and no valid strobe may appear. The bench produces both cases with 8-period frames and with strobes re-asserted at chosen periods. A queue-based model compares enables, bits, the valid strobe and the linear outputs on every clock.

// File: rtl/pcm_serial_port.sv
module pcm_serial_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_en,
  input  logic        law_mu,
  input  logic        bclk,
  input  logic        fsync,
  input  logic        rx_a,
  input  logic        rx_b,
  output logic [15:0] rx_lin_a,
  output logic [15:0] rx_lin_b,
  output logic        rx_valid,
  input  logic [15:0] tx_lin_a,
  input  logic [15:0] tx_lin_b,
  output logic        tx_a_d,
  output logic        tx_a_oe,
  output logic        tx_b_d,
  output logic        tx_b_oe
);

  function automatic logic [7:0] mu_enc(input logic [15:0] lin);
    logic [13:0] x, mag;
    logic [2:0]  seg;
    logic [3:0]  man;
    logic [7:0]  c;
    x = lin[15:2];
    mag = x[13] ? -x : x;
    if (mag > 14'd8158) mag = 14'd8158;
    mag = mag + 14'd33;
    seg = 3'd0;
    for (int i = 0; i < 8; i++) if (mag[i+5]) seg = 3'(i);
    man = 4'(mag >> ({1'b0, seg} + 4'd1));
    c = {1'b0, seg, man};
    return x[13] ? (c ^ 8'h7F) : (c ^ 8'hFF);
  endfunction

  function automatic logic [7:0] a_enc(input logic [15:0] lin);
    logic [12:0] x, mag;
    logic [2:0]  seg;
    logic [3:0]  man;
    logic [7:0]  c;
    x = lin[15:3];
    mag = x[12] ? ~x : x;
    seg = 3'd0;
    for (int i = 5; i < 12; i++) if (mag[i]) seg = 3'(i - 4);
    man = (seg < 3'd2) ? mag[4:1] : 4'(mag >> seg);
    c = {1'b0, seg, man};
    return x[12] ? (c ^ 8'h55) : (c ^ 8'hD5);
  endfunction

  function automatic logic [15:0] mu_dec(input logic [7:0] code);
    logic [7:0]  u;
    logic [15:0] t;
    u = ~code;
    t = {8'd0, 1'b1, u[3:0], 3'b100} << u[6:4];
    t = t - 16'd132;
    return u[7] ? -t : t;
  endfunction

  function automatic logic [15:0] a_dec(input logic [7:0] code);
    logic [7:0]  a;
    logic [15:0] t;
    a = code ^ 8'h55;
    if (a[6:4] == 3'd0) t = {8'd0, a[3:0], 4'b1000};
    else                t = {7'd0, 1'b1, a[3:0], 4'b1000} << (a[6:4] - 3'd1);
    return a[7] ? t : -t;
  endfunction

  logic       bclk_q;
  logic       rx_on, tx_on;
  logic [2:0] rx_cnt, tx_cnt;
  logic [6:0] rsh_a, rsh_b;
  logic [7:0] tsh_a, tsh_b;

  wire rise = bclk & ~bclk_q;
  wire fall = ~bclk & bclk_q;
  wire done = fall & ~fsync & rx_on & (rx_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0; rx_on <= 1'b0; tx_on <= 1'b0;
      rx_cnt <= '0; tx_cnt <= '0; rsh_a <= '0; rsh_b <= '0;
      tsh_a <= '0; tsh_b <= '0; rx_valid <= 1'b0;
      rx_lin_a <= '0; rx_lin_b <= '0;
    end else if (!pwr_en) begin
      bclk_q <= 1'b0; rx_on <= 1'b0; tx_on <= 1'b0;
      rx_cnt <= '0; tx_cnt <= '0; rsh_a <= '0; rsh_b <= '0;
      tsh_a <= '0; tsh_b <= '0; rx_valid <= 1'b0;
      rx_lin_a <= '0; rx_lin_b <= '0;
    end else begin
      bclk_q   <= bclk;
      rx_valid <= done;
      if (fall) begin
        rsh_a <= {rsh_a[5:0], rx_a};
        rsh_b <= {rsh_b[5:0], rx_b};
        if (fsync) begin
          rx_on  <= 1'b1;
          rx_cnt <= 3'd1;
        end else if (rx_on) begin
          rx_cnt <= rx_cnt + 3'd1;
          if (rx_cnt == 3'd7) rx_on <= 1'b0;
        end
      end
      if (done) begin
        rx_lin_a <= law_mu ? mu_dec({rsh_a, rx_a}) : a_dec({rsh_a, rx_a});
        rx_lin_b <= law_mu ? mu_dec({rsh_b, rx_b}) : a_dec({rsh_b, rx_b});
      end
      if (rise) begin
        if (fsync) begin
          tx_on  <= 1'b1;
          tx_cnt <= 3'd1;
          tsh_a  <= law_mu ? mu_enc(tx_lin_a) : a_enc(tx_lin_a);
          tsh_b  <= law_mu ? mu_enc(tx_lin_b) : a_enc(tx_lin_b);
        end else if (tx_on) begin
          if (tx_cnt == 3'd0) tx_on <= 1'b0;
          else begin
            tsh_a  <= {tsh_a[6:0], 1'b0};
            tsh_b  <= {tsh_b[6:0], 1'b0};
            tx_cnt <= tx_cnt + 3'd1;
          end
        end
      end
    end
  end

  assign tx_a_d  = tsh_a[7];
  assign tx_b_d  = tsh_b[7];
  assign tx_a_oe = tx_on & pwr_en;
  assign tx_b_oe = tx_on & pwr_en;

endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_en,
  input logic        bclk,
  input logic        fsync,
  input logic        rx_valid,
  input logic [15:0] rx_lin_a,
  input logic        tx_a_d,
  input logic        tx_a_oe,
  input logic        tx_b_oe
);

  // R1
  r1_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!tx_a_oe && !tx_b_oe && !rx_valid && rx_lin_a == 16'h0));

  // R2
  r2_valid_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(!bclk && !fsync && pwr_en));

  // R3
  r3_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4
  r4_slot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_a_oe) |-> $past(bclk && fsync));

  // R4
  r4_bit_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_en) && !$stable(tx_a_d)) |-> $past(bclk));

  // R5
  r5_slot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_a_oe) && pwr_en) |-> $past(bclk));

  // R8
  r8_restart_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bclk) && !bclk && fsync) |=> !rx_valid);

  // R9
  r9_pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> (!rx_valid && rx_lin_a == 16'h0));

  // R9
  r9_pd_exit_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (!tx_a_oe && !tx_b_oe));

endmodule

bind pcm_serial_port pcm_serial_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .bclk(bclk), .fsync(fsync),
  .rx_valid(rx_valid), .rx_lin_a(rx_lin_a), .tx_a_d(tx_a_d),
  .tx_a_oe(tx_a_oe), .tx_b_oe(tx_b_oe)
);

// File: tb/pcm_serial_port_tb_top.sv
module pcm_serial_port_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, pwr_en = 1'b1, law_mu = 1'b1;
  logic        bclk = 1'b0, fsync = 1'b0, rx_a = 1'b0, rx_b = 1'b0;
  logic [15:0] tx_lin_a = '0, tx_lin_b = '0;
  logic [15:0] rx_lin_a, rx_lin_b;
  logic        rx_valid, tx_a_d, tx_a_oe, tx_b_d, tx_b_oe;

  pcm_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .law_mu(law_mu),
    .bclk(bclk), .fsync(fsync), .rx_a(rx_a), .rx_b(rx_b),
    .rx_lin_a(rx_lin_a), .rx_lin_b(rx_lin_b), .rx_valid(rx_valid),
    .tx_lin_a(tx_lin_a), .tx_lin_b(tx_lin_b),
    .tx_a_d(tx_a_d), .tx_a_oe(tx_a_oe), .tx_b_d(tx_b_d), .tx_b_oe(tx_b_oe)
  );

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  // reference model state
  bit qa[$], qb[$], ra[$], rb[$];
  bit m_oe = 0, m_act = 0, m_val = 0, prev_b = 0, ca = 0, cb = 0;
  logic [15:0] m_la = '0, m_lb = '0;
  logic [7:0] obs_a;
  string ctx = "";

  function automatic logic [7:0] ref_mu_enc(logic [15:0] v);
    int x, mag, seg, man, code;
    x = $signed(v) >>> 2;
    mag = (x < 0) ? -x : x;
    if (mag > 8158) mag = 8158;
    mag += 33;
    seg = 0;
    while (mag >= (64 << seg)) seg++;
    man = (mag >> (seg + 1)) % 16;
    code = seg * 16 + man;
    return 8'((x < 0) ? (code ^ 127) : (code ^ 255));
  endfunction

  function automatic logic [7:0] ref_a_enc(logic [15:0] v);
    int x, mag, seg, man, code;
    x = $signed(v) >>> 3;
    mag = (x < 0) ? (-x - 1) : x;
    seg = 0;
    while (seg < 7 && mag >= (32 << seg)) seg++;
    man = (mag >> ((seg == 0) ? 1 : seg)) % 16;
    code = seg * 16 + man;
    return 8'((x < 0) ? (code ^ 85) : (code ^ 213));
  endfunction

  function automatic logic [15:0] ref_mu_dec(logic [7:0] c);
    int u, s, m, v;
    u = c ^ 255; s = (u >> 4) % 8; m = u % 16;
    v = ((m * 8 + 132) << s) - 132;
    return 16'((u >= 128) ? -v : v);
  endfunction

  function automatic logic [15:0] ref_a_dec(logic [7:0] c);
    int a, s, m, v;
    a = c ^ 85; s = (a >> 4) % 8; m = a % 16;
    v = (s == 0) ? (m * 16 + 8) : ((m * 16 + 264) << (s - 1));
    return 16'((a >= 128) ? v : -v);
  endfunction

  function automatic logic [7:0] enc(logic [15:0] v);
    return law_mu ? ref_mu_enc(v) : ref_a_enc(v);
  endfunction

  function automatic logic [15:0] dec(logic [7:0] c);
    return law_mu ? ref_mu_dec(c) : ref_a_dec(c);
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s %s: actual=%h expected=%h t=%0t", tag, ctx, what, act, exp, $time);
    end
  endtask

  task automatic model(bit b, bit fs, bit xa, bit xb);
    logic [7:0] ea, eb;
    if (!rst_n || !pwr_en) begin
      qa.delete(); qb.delete(); ra.delete(); rb.delete();
      m_oe = 0; m_act = 0; m_val = 0; m_la = '0; m_lb = '0; prev_b = 0;
      return;
    end
    m_val = 0;
    if (b && !prev_b) begin
      if (fs) begin
        ea = enc(tx_lin_a); eb = enc(tx_lin_b);
        qa.delete(); qb.delete();
        for (int i = 7; i >= 0; i--) begin qa.push_back(ea[i]); qb.push_back(eb[i]); end
        m_oe = 1; ca = qa.pop_front(); cb = qb.pop_front();
      end else if (m_oe) begin
        if (qa.size() == 0) m_oe = 0;
        else begin ca = qa.pop_front(); cb = qb.pop_front(); end
      end
    end
    if (!b && prev_b) begin
      if (fs) begin
        ra.delete(); rb.delete(); ra.push_back(xa); rb.push_back(xb); m_act = 1;
      end else if (m_act) begin
        ra.push_back(xa); rb.push_back(xb);
        if (ra.size() == 8) begin
          for (int i = 0; i < 8; i++) begin ea[7-i] = ra[i]; eb[7-i] = rb[i]; end
          m_la = dec(ea); m_lb = dec(eb); m_val = 1; m_act = 0;
        end
      end
    end
    prev_b = b;
  endtask

  task automatic compare();
    string ot, lt;
    ot = !rst_n ? "R1" : (!pwr_en ? "R9" : (m_oe ? "R4" : "R5"));
    lt = law_mu ? "R6" : "R7";
    chk(ot, "tx_a_oe", 16'(tx_a_oe), 16'(m_oe));
    chk(ot, "tx_b_oe", 16'(tx_b_oe), 16'(m_oe));
    if (m_oe) begin
      chk(lt, "tx_a_d R4", 16'(tx_a_d), 16'(ca));
      chk(lt, "tx_b_d R4", 16'(tx_b_d), 16'(cb));
    end
    chk(rst_n ? "R3" : "R1", "rx_valid", 16'(rx_valid), 16'(m_val));
    chk(rst_n ? lt : "R1", "rx_lin_a R2", rx_lin_a, m_la);
    chk(rst_n ? lt : "R1", "rx_lin_b R2", rx_lin_b, m_lb);
  endtask

  task automatic step(bit b, bit fs, bit xa, bit xb);
    bclk = b; fsync = fs; rx_a = xa; rx_b = xb;
    @(negedge clk);
    model(b, fs, xa, xb);
    compare();
  endtask

  task automatic frame(logic [7:0] ba, logic [7:0] bb, logic [15:0] la, logic [15:0] lb,
                       int nper, int trunc_at, int flip_at);
    int st, k;
    bit fs, xa, xb;
    st = 0;
    tx_lin_a = la; tx_lin_b = lb;
    for (int i = 0; i < nper; i++) begin
      if (i == flip_at) law_mu = ~law_mu;
      fs = (i == 0) || (i == trunc_at);
      if (fs) st = i;
      k = i - st;
      xa = (k < 8) ? ba[7-k] : 1'b1;
      xb = (k < 8) ? bb[7-k] : 1'b0;
      step(1, fs, xa, xb);
      if (k < 8) obs_a = {obs_a[6:0], tx_a_d};
      step(1, fs, xa, xb);
      step(0, fs, xa, xb);
      step(0, fs, xa, xb);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] e;
    @(negedge clk);
    // R1: reset state
    repeat (4) step(0, 0, 0, 0);
    chk("R1", "reset oe", 16'(tx_a_oe | tx_b_oe), 16'h0);
    chk("R1", "reset lin", rx_lin_a | rx_lin_b, 16'h0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    chk("R1", "post-reset valid", 16'(rx_valid), 16'h0);
    repeat (3) step(0, 0, 0, 0);

    // R6 golden values
    law_mu = 1'b1;
    frame(8'hFF, 8'h80, 16'h0000, 16'h7FFC, 10, -1, -1);
    chk("R6", "enc 0", 16'(obs_a), 16'h00FF);
    chk("R6", "dec FF", rx_lin_a, 16'h0000);
    chk("R6", "dec 80", rx_lin_b, 16'h7D7C);
    frame(8'h7E, 8'h00, 16'h7FFC, 16'h0000, 10, -1, -1);
    chk("R6", "enc max", 16'(obs_a), 16'h0080);
    chk("R6", "dec 7E", rx_lin_a, 16'hFFF8);
    frame(8'h80, 8'h00, 16'hFFFC, 16'h0000, 10, -1, -1);
    chk("R6", "enc -1", 16'(obs_a), 16'h007E);

    // R7 golden values
    law_mu = 1'b0;
    frame(8'hD5, 8'hAA, 16'h0000, 16'h0000, 10, -1, -1);
    chk("R7", "enc 0", 16'(obs_a), 16'h00D5);
    chk("R7", "dec D5", rx_lin_a, 16'h0008);
    chk("R7", "dec AA", rx_lin_b, 16'h7E00);
    frame(8'h55, 8'h00, 16'hFFF8, 16'h0000, 10, -1, -1);
    chk("R7", "enc -1", 16'(obs_a), 16'h0055);
    chk("R7", "dec 55", rx_lin_a, 16'hFFF8);
    frame(8'h12, 8'h00, 16'h7FF8, 16'h0000, 10, -1, -1);
    chk("R7", "enc max", 16'(obs_a), 16'h00AA);

    // R4 R5 R2 R3: random frames, mixed gaps incl. back-to-back
    ctx = "random";
    for (int f = 0; f < 80; f++) begin
      law_mu = 1'($urandom % 2);
      frame(8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom), 8 + $urandom % 5, -1, -1);
    end
    ctx = "back-to-back";
    for (int f = 0; f < 10; f++)
      frame(8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom), 8, -1, -1);
    repeat (2) step(0, 0, 0, 0);

    // R8: early strobes, including on the last-bit edge
    ctx = "R8";
    law_mu = 1'b1;
    frame(8'h3C, 8'hC3, 16'h1234, 16'hBEEF, 18, 5, -1);
    chk("R8", "rx after restart", rx_lin_a, ref_mu_dec(8'h3C));
    chk("R8", "tx after reload", 16'(obs_a), 16'(ref_mu_enc(16'h1234)));
    frame(8'h5A, 8'hA5, 16'h8001, 16'h4000, 18, 7, -1);
    chk("R8", "rx restart at bit0", rx_lin_a, ref_mu_dec(8'h5A));

    // R10: law flip mid-frame
    ctx = "R10";
    law_mu = 1'b1;
    frame(8'h9D, 8'h11, 16'h2468, 16'h0F0F, 10, -1, 3);
    chk("R10", "tx uses law at slot start", 16'(obs_a), 16'(ref_mu_enc(16'h2468)));
    chk("R10", "rx uses law at completion", rx_lin_a, ref_a_dec(8'h9D));

    // R9: power-down mid-frame
    ctx = "R9";
    law_mu = 1'b0;
    frame(8'hF0, 8'h0F, 16'h7777, 16'h8888, 4, -1, -1);
    pwr_en = 1'b0;
    step(0, 0, 0, 0);
    chk("R9", "pd oe", 16'(tx_a_oe | tx_b_oe), 16'h0);
    repeat (4) step(0, 0, 0, 0);
    chk("R9", "pd lin", rx_lin_a, 16'h0000);
    pwr_en = 1'b1;
    repeat (4) step(0, 0, 0, 0);
    chk("R9", "exit oe", 16'(tx_a_oe), 16'h0);
    frame(8'h6B, 8'h0F, 16'h1111, 16'h8888, 10, -1, -1);
    e = ref_a_enc(16'h1111);
    chk("R9", "frame after pd", 16'(obs_a), 16'(e));

    // R1: reset mid-frame
    ctx = "R1";
    frame(8'hAB, 8'hCD, 16'h5555, 16'h6666, 5, -1, -1);
    rst_n = 1'b0;
    step(0, 0, 0, 0);
    chk("R1", "reset mid-frame oe", 16'(tx_a_oe | tx_b_oe), 16'h0);
    chk("R1", "reset mid-frame lin", rx_lin_b, 16'h0000);
    rst_n = 1'b1;
    repeat (2) step(0, 0, 0, 0);
    frame(8'h21, 8'h43, 16'hC000, 16'h3000, 10, -1, -1);
    chk("R7", "frame after reset", rx_lin_a, ref_a_dec(8'h21));

    report();
  end

endmodule